// File: doc/BRIEF.md
# Selectable-Tap Timer Interrupt Generator

This block turns a free-running binary counter into a periodic interrupt for a processor. The counter runs on its own timer clock, which has no fixed relation to the processor clock. Software writes a tap index, and that index picks one counter bit as the interrupt source. A chosen bit stays high for half of its period, which can span many processor cycles, so it never drives the interrupt line directly.

The chosen bit is first registered in the timer domain. This keeps it free of glitches while the index changes. It is then carried into the processor domain through a two-flop synchronizer. A rising-edge detector there compares the synchronized level with its value one processor cycle earlier. The result is one interrupt pulse, one processor cycle wide, for every period of the chosen bit. Picking bit k gives one pulse every 2^(k+1) timer cycles. For example, bit 4 gives one pulse every 32 timer cycles.

Changing the tap could make the synchronized level jump from 0 to 1, and that jump is not a real event. For this reason every write to the tap index opens a blanking window of `BLANK_CYC` processor cycles. During that window the interrupt is held low, and the edge history keeps following the new level.

Top module: `tap_irq_gen`

## Requirements
- R1: While `tmr_rst_n` or `cpu_rst_n` is low, and until each reset has been re-timed by two flops of its own clock, `irq` is 0. The counter, the registered tap, the synchronizer flops, the edge history and the tap index are all cleared to 0.
- R2: The counter is `CNT_W` bits wide (16 by default) and wraps around. After `tmr_rst_n` rises, it first holds value 1 after the third rising edge of `tmr_clk`. It then adds exactly one on every later timer edge.
- R3: When `sel_we` is high at a rising edge of `cpu_clk`, `sel_wdata` is stored as the tap index. An index value k selects counter bit k (bit 0 is the least significant bit). The index is 0 after reset.
- R4: `irq` is never high on two processor cycles in a row. Each rising edge of the selected bit that falls outside a blanking window gives exactly one high cycle.
- R5: With a fixed tap index k, consecutive `irq` pulses are 2^(k+1) timer periods apart. With timer period = 3 processor periods, index 0 gives 6 processor cycles, index 1 gives 12 and index 4 gives 96.
- R6: The registered tap is sampled at each `cpu_clk` edge into a sequence L[j]. Then `irq` is high in the cycle after edge j exactly when L[j-1]=1, L[j-2]=0, and no blanking window is open.
- R7: A write to the tap index, with the same value or a new one, holds `irq` at 0 for `BLANK_CYC` processor cycles, counted from the write edge. No pulse may come from the change of tap.
- R8: If both resets are applied in mid-run and then released, counting restarts from 0 with tap index 0. Pulses then follow R2, R5 and R6 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmr_clk | input | 1 | Timer clock that drives the counter |
| tmr_rst_n | input | 1 | Asynchronous active-low reset of the timer domain |
| cpu_clk | input | 1 | Processor clock |
| cpu_rst_n | input | 1 | Asynchronous active-low reset of the processor domain |
| sel_we | input | 1 | Write strobe for the tap index, processor domain |
| sel_wdata | input | SEL_W | New tap index (counter bit number) |
| irq | output | 1 | Interrupt pulse, one processor cycle wide |

## Verification
The bench keeps a model of the counter that counts timer edges, together with a record of the tap level seen at every processor edge. With these it predicts `irq` on every processor cycle. It therefore catches a design that passes the raw level through: that design would hold `irq` high for three or more cycles. It also catches a synchronizer with one flop too many or too few, because every pulse would then land one cycle away from the prediction. Writes that open the blanking window are made both with the same tap index and with a new one, and also in a rapid burst. A design whose history does not follow the new level would then fire a false pulse as soon as the window closes. Measured pulse spacing for indices 0, 1, 4 and 12 exposes a tap multiplexer that picks the wrong bit. A reset in mid-run shows whether the counter and the tap index really return to 0.

// File: rtl/tapirq_pkg.sv
package tapirq_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  // bits needed to hold the value n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tapirq_rst_sync.sv
module tapirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/tapirq_sync.sv
module tapirq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tapirq_tap_src.sv
module tapirq_tap_src #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             tmr_clk,
  input  logic             tmr_rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tap_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [SEL_W-1:0] sel_t;
  logic             tap_d;
  logic             tap_q;

  // index is quasi-static; one stray tap value during a change is blanked downstream
  tapirq_sync #(.WIDTH(SEL_W), .STAGES(STAGES)) u_sel_sync (
    .clk   (tmr_clk),
    .rst_n (tmr_rst_n),
    .d_i   (sel_i),
    .q_o   (sel_t)
  );

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (int'(sel_t) < int'(CNT_W)) tap_d = cnt_q[sel_t];
    else                           tap_d = 1'b0;
  end

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tap_q <= tap_d;
    end
  end

  assign tap_o = tap_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/tapirq_edge_pulse.sv
module tapirq_edge_pulse #(
  parameter int unsigned STAGES    = 2,
  parameter int unsigned BLANK_CYC = 16
) (
  input  logic cpu_clk,
  input  logic cpu_rst_n,
  input  logic tap_async,
  input  logic blank_start,
  output logic irq_o
);
  localparam int unsigned BW = tapirq_pkg::cnt_bits(BLANK_CYC);

  logic          tap_s;
  logic          hist_q;
  logic [BW-1:0] blank_q;
  logic [BW-1:0] blank_d;
  logic          blank_en;

  tapirq_sync #(.WIDTH(1), .STAGES(STAGES)) u_tap_sync (
    .clk   (cpu_clk),
    .rst_n (cpu_rst_n),
    .d_i   (tap_async),
    .q_o   (tap_s)
  );

  always_comb begin
    blank_en = blank_start || (blank_q != '0);
    if (blank_start) blank_d = BW'(BLANK_CYC);
    else             blank_d = blank_q - 1'b1;
  end

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      hist_q  <= 1'b0;
      blank_q <= '0;
    end else begin
      hist_q <= tap_s;
      if (blank_en) blank_q <= blank_d;
    end
  end

  assign irq_o = tap_s & ~hist_q & (blank_q == '0);
endmodule

// File: rtl/tap_irq_gen.sv
module tap_irq_gen #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SEL_W     = $clog2(CNT_W),
  parameter int unsigned BLANK_CYC = 16
) (
  input  logic             tmr_clk,
  input  logic             tmr_rst_n,
  input  logic             cpu_clk,
  input  logic             cpu_rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic             irq
);
  localparam int unsigned DEPTH = tapirq_pkg::SYNC_DEPTH;

  logic             tmr_rst_s;
  logic             cpu_rst_s;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             tap_level;
  logic [CNT_W-1:0] cnt_val;

  tapirq_rst_sync #(.STAGES(DEPTH)) u_tmr_rst (
    .clk (tmr_clk), .arst_n (tmr_rst_n), .rst_n_o (tmr_rst_s)
  );

  tapirq_rst_sync #(.STAGES(DEPTH)) u_cpu_rst (
    .clk (cpu_clk), .arst_n (cpu_rst_n), .rst_n_o (cpu_rst_s)
  );

  always_comb begin
    sel_d = sel_we ? sel_wdata : sel_q;
  end

  always_ff @(posedge cpu_clk or negedge cpu_rst_s) begin
    if (!cpu_rst_s) sel_q <= '0;
    else            sel_q <= sel_d;
  end

  tapirq_tap_src #(.CNT_W(CNT_W), .SEL_W(SEL_W), .STAGES(DEPTH)) u_src (
    .tmr_clk   (tmr_clk),
    .tmr_rst_n (tmr_rst_s),
    .sel_i     (sel_q),
    .tap_o     (tap_level),
    .cnt_o     (cnt_val)
  );

  tapirq_edge_pulse #(.STAGES(DEPTH), .BLANK_CYC(BLANK_CYC)) u_edge (
    .cpu_clk     (cpu_clk),
    .cpu_rst_n   (cpu_rst_s),
    .tap_async   (tap_level),
    .blank_start (sel_we),
    .irq_o       (irq)
  );
endmodule

// File: rtl/tapirq_chk.sv
module tapirq_chk #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BLANK_CYC = 16
) (
  input logic             cpu_clk,
  input logic             cpu_rst_s,
  input logic             tmr_clk,
  input logic             tmr_rst_s,
  input logic             sel_we,
  input logic             tap,
  input logic [CNT_W-1:0] cnt,
  input logic             irq
);
  int unsigned since_wr;

  always_ff @(posedge cpu_clk or negedge cpu_rst_s) begin
    if (!cpu_rst_s)                since_wr <= BLANK_CYC;
    else if (sel_we)               since_wr <= 0;
    else if (since_wr < BLANK_CYC) since_wr <= since_wr + 1;
  end

  // R1
  irq_reset_low_chk: assert property (@(posedge cpu_clk) !cpu_rst_s |-> !irq);

  // R4
  irq_single_cycle_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_s)
    irq |=> !irq);

  // R6
  irq_latency_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_s)
    irq |-> ($past(tap, 2) && !$past(tap, 3)));

  // R7
  blank_after_write_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_s)
    sel_we |=> !irq);

  // R7
  blank_window_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_s)
    (since_wr < BLANK_CYC) |-> !irq);

  // R2
  cnt_step_chk: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_s)
    $past(tmr_rst_s) |-> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

bind tap_irq_gen tapirq_chk #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_chk (
  .cpu_clk   (cpu_clk),
  .cpu_rst_s (cpu_rst_s),
  .tmr_clk   (tmr_clk),
  .tmr_rst_s (tmr_rst_s),
  .sel_we    (sel_we),
  .tap       (tap_level),
  .cnt       (cnt_val),
  .irq       (irq)
);

// File: tb/tap_irq_gen_tb_top.sv
module tap_irq_gen_tb_top;
  localparam int CNT_W = 16;
  localparam int SEL_W = 4;
  localparam int BLANK = 16;

  logic tmr_clk = 1'b0;
  logic cpu_clk = 1'b0;
  logic tmr_rst_n = 1'b0;
  logic cpu_rst_n = 1'b0;
  logic sel_we = 1'b0;
  logic [SEL_W-1:0] sel_wdata = '0;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  tap_irq_gen #(.CNT_W(CNT_W), .BLANK_CYC(BLANK)) dut_i (
    .tmr_clk, .tmr_rst_n, .cpu_clk, .cpu_rst_n, .sel_we, .sel_wdata, .irq
  );

  // 125 MHz processor clock: rising edges at 4, 12, 20 ns ...
  initial forever #4 cpu_clk = ~cpu_clk;
  // timer period 24 ns: rising edges at 8, 32, 56 ns ... (between processor edges)
  initial begin
    #8 tmr_clk = 1'b1;
    forever #12 tmr_clk = ~tmr_clk;
  end

  // ---- reference model ----
  int m_edges = 0;
  int m_sel = 0;
  bit m_tap = 1'b0;
  bit lvl_q[$];
  int m_blank = 0;
  bit exp_irq = 1'b0;

  always @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      m_edges = 0;
      m_tap = 1'b0;
    end else begin
      logic [15:0] cval;
      m_edges = m_edges + 1;
      cval = (m_edges >= 3) ? 16'(m_edges - 3) : 16'd0;
      m_tap = cval[m_sel];
    end
  end

  always @(posedge cpu_clk) begin
    cyc = cyc + 1;
    if (!cpu_rst_n) begin
      lvl_q = {1'b0, 1'b0, 1'b0};
      m_blank = 0;
      m_sel = 0;
    end else begin
      if (sel_we) begin
        m_blank = BLANK;
        m_sel = int'(sel_wdata);
      end else if (m_blank > 0) m_blank = m_blank - 1;
      lvl_q.push_front(m_tap);
      void'(lvl_q.pop_back());
    end
    exp_irq = lvl_q[1] && !lvl_q[2] && (m_blank == 0);
  end

  task automatic check(input string req, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  always @(negedge cpu_clk) begin
    if (cmp_on) check((m_blank != 0) ? "R7" : cur_req, int'(irq), int'(exp_irq));
  end

  task automatic write_sel(input int v);
    @(negedge cpu_clk);
    sel_we = 1'b1;
    sel_wdata = SEL_W'(v);
    @(negedge cpu_clk);
    sel_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge cpu_clk);
  endtask

  // R5: cycles between two consecutive pulses
  task automatic measure(input int expv, input int limit);
    int t = 0;
    int gap = 0;
    while (!irq && t < limit) begin @(negedge cpu_clk); t++; end
    @(negedge cpu_clk);
    gap = 1;
    while (!irq && gap < limit) begin @(negedge cpu_clk); gap++; end
    check("R5", gap, expv);
  endtask

  initial begin : watchdog
    wait (cyc >= 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog cycle %0d: actual hung expected done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    lvl_q = {1'b0, 1'b0, 1'b0};
    wait_cyc(5);
    check("R1", int'(irq), 0);
    @(negedge cpu_clk);
    tmr_rst_n = 1'b1;
    cpu_rst_n = 1'b1;
    cmp_on = 1'b1;
    cur_req = "R2";
    wait_cyc(60);
    cur_req = "R6";
    measure(6, 100);
    wait_cyc(40);

    cur_req = "R3";
    write_sel(4);
    wait_cyc(200);
    measure(96, 400);

    write_sel(1);
    wait_cyc(50);
    measure(12, 100);

    cur_req = "R7";
    write_sel(1);
    wait_cyc(60);
    for (int i = 0; i < 6; i++) begin
      write_sel((i % 2 == 0) ? 0 : 3);
      wait_cyc(5);
    end
    wait_cyc(80);

    cur_req = "R3";
    write_sel(12);
    measure(24576, 60000);

    cur_req = "R4";
    write_sel(0);
    wait_cyc(100);

    cur_req = "R8";
    write_sel(2);
    wait_cyc(30);
    @(negedge cpu_clk);
    cmp_on = 1'b0;
    tmr_rst_n = 1'b0;
    cpu_rst_n = 1'b0;
    wait_cyc(8);
    check("R1", int'(irq), 0);
    @(negedge cpu_clk);
    tmr_rst_n = 1'b1;
    cpu_rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_cyc(100);
    measure(6, 100);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule